// File: doc/BRIEF.md
# Latency-Emulating Line Memory Responder

This block stands in for external memory behind a cache's line-fill port during verification. A requester presents one line-sized request per cycle over a valid/ready handshake, carrying a line address, a tag, write data and per-byte enables. Writes are merged into a local line array in the cycle they are accepted and produce no reply. Reads capture the addressed line and the tag into a pending table, where each entry counts down a fixed latency. Once an entry's count has reached zero it may be returned to the consumer together with its tag.

Replies leave one per cycle. Among the entries whose count is zero, the one nearest the bottom of the table is chosen. It leaves only when the consumer shows ready. The entries above it then slide down one place. Because all entries start with the same latency, data comes back in the order the reads were accepted, even after a long consumer stall.

A stall-mode input lets the responder apply back-pressure. The throttle has four gate states: GATE_OPEN, GATE_TICK, GATE_CROWD and GATE_BRIM. The gate is recomputed each cycle from a free-running phase counter and from the table occupancy. It moves to GATE_TICK whenever the phase is zero in stall mode. Otherwise it moves to GATE_CROWD when stall mode is on and the occupancy has reached the limit. Otherwise it moves to GATE_BRIM when the table is completely full. In every other case it returns to GATE_OPEN. Only GATE_OPEN raises request ready.

Top module: `line_mem_responder`

## Requirements
- R1: After reset the pending table is empty, so rsp_valid is low. The phase counter restarts at zero.
- R2: A read accepted in cycle k is offered on rsp_valid in cycle k+LATENCY+1. This assumes rsp_ready is high and no older entry is waiting. Before that cycle rsp_valid stays low.
- R3: Of the entries whose count is zero, the lowest-index one is returned. At most one entry leaves per cycle. The remaining entries close the gap, so a backlog drains on consecutive ready cycles in acceptance order.
- R4: rsp_valid is high only in a cycle where rsp_ready is high and some entry has a count of zero.
- R5: An accepted write updates only the bytes whose enable bit is set. Enable bit b controls data bits [8b+7:8b] of the line, and line address a maps to byte address a×LINE_BYTES. A write never produces a response.
- R6: In stall mode, req_ready is low in every cycle whose index since reset, taken modulo PERIOD, is zero. The first cycle after reset has index 0.
- R7: In stall mode, req_ready is low whenever the table holds LIMIT or more entries.
- R8: With stall mode off, req_ready is high unless the table holds DEPTH entries.
- R9: A request presented while req_ready is low is not taken. It writes nothing and creates no entry.
- R10: Read data is the line content at the moment of acceptance. A later write to the same line does not change a reply that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_mode | input | 1 | Enables periodic and occupancy back-pressure |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Line address |
| req_tag | input | TAG_W | Tag returned with a read reply |
| req_wdata | input | 8×LINE_BYTES | Write line data |
| req_byteen | input | LINE_BYTES | Per-byte write enables |
| rsp_valid | output | 1 | Reply delivered this cycle |
| rsp_ready | input | 1 | Consumer can take a reply |
| rsp_tag | output | TAG_W | Tag of the reply |
| rsp_data | output | 8×LINE_BYTES | Line data of the reply |

## Verification
The bench builds the responder with the following parameters:

- 8 lines of 4 bytes
- 4-bit tags
- a latency of 3
- a 4-entry table
- a stall period of 5
- an occupancy limit of 3

With only four byte lanes, all 16 enable patterns can be swept against a single line and read back. A 4-deep table fills after four back-to-back reads, which brings the full-table refusal and a complete drain in acceptance order within a few cycles. A period of 5 and a limit of 3 let the periodic and occupancy stalls both occur, and coincide, inside a window of about a dozen cycles.

// File: rtl/line_mem_pkg.sv
`timescale 1ns/1ps
package line_mem_pkg;

    // Request gate decided by the throttle each cycle
    typedef enum logic [1:0] {
        GATE_OPEN,   // request accepted
        GATE_TICK,   // periodic stall slot
        GATE_CROWD,  // occupancy at or above the stall limit
        GATE_BRIM    // table completely full
    } gate_e;

endpackage

// File: rtl/line_mem_store.sv
`timescale 1ns/1ps
module line_mem_store #(
    parameter int ADDR_W     = 4,
    parameter int LINE_BYTES = 8,
    localparam int LINES     = 1 << ADDR_W,
    localparam int DATA_W    = 8 * LINE_BYTES
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [DATA_W-1:0]     rd_data
);

    // One array per byte lane so each enable bit owns its storage
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [7:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_q[wr_addr] <= wr_data[8*b +: 8];
            end
        end

        assign rd_data[8*b +: 8] = lane_q[rd_addr];
    end

endmodule

// File: rtl/line_mem_pending.sv
`timescale 1ns/1ps
module line_mem_pending #(
    parameter int DEPTH   = 8,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 64,
    parameter int LATENCY = 4,
    localparam int OCC_W  = $clog2(DEPTH + 1),
    localparam int CNT_W  = $clog2(LATENCY + 1),
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [TAG_W-1:0]  push_tag,
    input  logic [DATA_W-1:0] push_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [DATA_W-1:0] rsp_data,
    output logic [OCC_W-1:0]  occupancy,
    output logic              full
);

    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [TAG_W-1:0]  tag_d  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    logic [CNT_W-1:0]  cnt_d  [DEPTH];
    logic [OCC_W-1:0]  occ_q, occ_d;

    logic              found;
    logic [IDX_W-1:0]  pick;
    logic              fire;
    logic [OCC_W-1:0]  slot;

    function automatic logic [CNT_W-1:0] tick_down(input logic [CNT_W-1:0] c);
        return (c != '0) ? c - 1'b1 : c;
    endfunction

    // Lowest live entry whose countdown has run out
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && (OCC_W'(i) < occ_q) && (cnt_q[i] == '0)) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    assign fire = found && rsp_ready;
    assign slot = occ_q - OCC_W'(fire);

    // Next table image: count down, close the gap, append the new read
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int src;
            src = ((i + 1) < DEPTH) ? i + 1 : i;
            tag_d[i]  = tag_q[i];
            data_d[i] = data_q[i];
            cnt_d[i]  = tick_down(cnt_q[i]);
            if (fire && (IDX_W'(i) >= pick)) begin
                tag_d[i]  = tag_q[src];
                data_d[i] = data_q[src];
                cnt_d[i]  = tick_down(cnt_q[src]);
            end
            if (push && (OCC_W'(i) == slot)) begin
                tag_d[i]  = push_tag;
                data_d[i] = push_data;
                cnt_d[i]  = CNT_W'(LATENCY);
            end
        end
        occ_d = occ_q - OCC_W'(fire) + OCC_W'(push);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                cnt_q[i] <= '0;
            end
        end else begin
            occ_q <= occ_d;
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]  <= tag_d[i];
                data_q[i] <= data_d[i];
                cnt_q[i]  <= cnt_d[i];
            end
        end
    end

    assign rsp_valid = fire;
    assign rsp_tag   = tag_q[pick];
    assign rsp_data  = data_q[pick];
    assign occupancy = occ_q;
    assign full      = (occ_q == OCC_W'(DEPTH));

    // R3: a delivered reply leaves the table
    p_drop_one_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !push) |=> (occupancy == $past(occupancy) - 1'b1));

    // R2: a new entry starts with the full latency
    p_fresh_count_r2: assert property (@(posedge clk) disable iff (rst)
        push |=> (cnt_q[IDX_W'($past(slot))] == CNT_W'(LATENCY)));

    // R8: the table never overflows
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    // R4: nothing to return from an empty table
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (occupancy == '0) |-> !rsp_valid);

endmodule

// File: rtl/line_mem_throttle.sv
`timescale 1ns/1ps
module line_mem_throttle
    import line_mem_pkg::*;
#(
    parameter int PERIOD = 7,
    parameter int LIMIT  = 6,
    parameter int OCC_W  = 4,
    localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall_mode,
    input  logic [OCC_W-1:0] occupancy,
    input  logic             table_full,
    output logic             req_ready
);

    logic [PH_W-1:0] phase_q;
    gate_e           gate;

    // Free-running phase counter
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_q == PH_W'(PERIOD - 1)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Gate selection, highest-priority cause first
    always_comb begin
        if (stall_mode && (phase_q == '0)) begin
            gate = GATE_TICK;
        end else if (stall_mode && (occupancy >= OCC_W'(LIMIT))) begin
            gate = GATE_CROWD;
        end else if (table_full) begin
            gate = GATE_BRIM;
        end else begin
            gate = GATE_OPEN;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        unique case (gate)
            GATE_OPEN:  req_ready = 1'b1;
            GATE_TICK:  req_ready = 1'b0;
            GATE_CROWD: req_ready = 1'b0;
            GATE_BRIM:  req_ready = 1'b0;
        endcase
    end

    // R6: the phase wraps back to the stall slot
    p_phase_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_W'(PERIOD - 1)) |=> (phase_q == '0));

endmodule

// File: rtl/line_mem_responder.sv
`timescale 1ns/1ps
module line_mem_responder
    import line_mem_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int LINE_BYTES = 8,
    parameter int TAG_W      = 6,
    parameter int LATENCY    = 4,
    parameter int DEPTH      = 8,
    parameter int PERIOD     = 7,
    parameter int LIMIT      = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stall_mode,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [TAG_W-1:0]        req_tag,
    input  logic [8*LINE_BYTES-1:0] req_wdata,
    input  logic [LINE_BYTES-1:0]   req_byteen,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [TAG_W-1:0]        rsp_tag,
    output logic [8*LINE_BYTES-1:0] rsp_data
);

    localparam int DATA_W = 8 * LINE_BYTES;
    localparam int OCC_W  = $clog2(DEPTH + 1);

    logic              accept;
    logic              wr_en;
    logic              push;
    logic [DATA_W-1:0] line_now;
    logic [OCC_W-1:0]  occupancy;
    logic              full;

    assign accept = req_valid && req_ready;
    assign wr_en  = accept && req_write;
    assign push   = accept && !req_write;

    line_mem_store #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (req_addr),
        .wr_data (req_wdata),
        .wr_be   (req_byteen),
        .rd_addr (req_addr),
        .rd_data (line_now)
    );

    line_mem_pending #(
        .DEPTH   (DEPTH),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) pending_i (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_tag  (req_tag),
        .push_data (line_now),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_tag   (rsp_tag),
        .rsp_data  (rsp_data),
        .occupancy (occupancy),
        .full      (full)
    );

    line_mem_throttle #(
        .PERIOD (PERIOD),
        .LIMIT  (LIMIT),
        .OCC_W  (OCC_W)
    ) throttle_i (
        .clk        (clk),
        .rst        (rst),
        .stall_mode (stall_mode),
        .occupancy  (occupancy),
        .table_full (full),
        .req_ready  (req_ready)
    );

    // R7: a crowded table refuses requests in stall mode
    p_crowd_block_r7: assert property (@(posedge clk) disable iff (rst)
        (stall_mode && (occupancy >= OCC_W'(LIMIT))) |-> !req_ready);

    // R4: a reply is only delivered to a ready consumer
    p_rsp_ready_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_ready);

endmodule

// File: tb/line_mem_responder_tb.sv
`timescale 1ns/1ps
module line_mem_responder_tb_top;

    localparam int AW = 3, LB = 4, TW = 4, LAT = 3, DEP = 4, PER = 5, LIM = 3;
    localparam int DW = 8 * LB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic i_sm = 1'b0, i_v = 1'b0, i_w = 1'b0, i_rr = 1'b1;
    logic [AW-1:0] i_a = '0;
    logic [TW-1:0] i_t = '0;
    logic [DW-1:0] i_d = '0;
    logic [LB-1:0] i_be = '0;
    logic req_ready, rsp_valid;
    logic [TW-1:0] rsp_tag;
    logic [DW-1:0] rsp_data;

    always #5 clk = ~clk;

    line_mem_responder #(
        .ADDR_W (AW), .LINE_BYTES (LB), .TAG_W (TW), .LATENCY (LAT),
        .DEPTH (DEP), .PERIOD (PER), .LIMIT (LIM)
    ) dut_i (
        .clk (clk), .rst (rst), .stall_mode (i_sm),
        .req_valid (i_v), .req_ready (req_ready), .req_write (i_w),
        .req_addr (i_a), .req_tag (i_t), .req_wdata (i_d), .req_byteen (i_be),
        .rsp_valid (rsp_valid), .rsp_ready (i_rr), .rsp_tag (rsp_tag), .rsp_data (rsp_data)
    );

    int n_run = 0, n_fail = 0, idx = 0, s_idx = 0;
    bit done = 1'b0;
    logic s_rdy, s_rv;
    logic [TW-1:0] s_tag;
    logic [DW-1:0] s_data;
    logic [DW-1:0] bm [8];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock cycle: inputs already set, sample between edges
    task automatic cyc();
        #1;
        s_rdy = req_ready; s_rv = rsp_valid; s_tag = rsp_tag; s_data = rsp_data;
        s_idx = idx;
        @(negedge clk);
        idx++;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [LB-1:0] be);
        i_v = 1'b1; i_w = 1'b1; i_a = a; i_d = d; i_be = be;
        cyc();
        i_v = 1'b0;
        chk(s_rdy == 1'b1, "R8 write ready", s_rdy, 1);
        chk(s_rv == 1'b0, "R5 write no reply", s_rv, 0);
        for (int b = 0; b < LB; b++) if (be[b]) bm[a][8*b +: 8] = d[8*b +: 8];
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [TW-1:0] t, input string lbl);
        i_v = 1'b1; i_w = 1'b0; i_a = a; i_t = t;
        cyc();
        i_v = 1'b0;
        chk(s_rdy == 1'b1, "R8 read ready", s_rdy, 1);
        for (int k = 0; k < LAT; k++) begin
            cyc();
            chk(s_rv == 1'b0, "R2 early reply", s_rv, 0);
        end
        cyc();
        chk(s_rv == 1'b1, "R2 reply on time", s_rv, 1);
        chk(s_tag == t, "R2 reply tag", s_tag, t);
        chk(s_data == bm[a], lbl, s_data, bm[a]);
    endtask

    initial begin
        #(10 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] q_tag [4];
        logic [DW-1:0] q_dat [4];
        int occ;
        logic [DW-1:0] old;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        idx = 0;

        // R1 reset state
        cyc();
        chk(s_rv == 1'b0, "R1 reset rsp_valid", s_rv, 0);
        chk(s_rdy == 1'b1, "R1 ready after reset", s_rdy, 1);

        // Fill every line, then read each back
        for (int l = 0; l < 8; l++) do_write(AW'(l), 32'h3C5A_0000 + 32'(l) * 32'h0001_0203, 4'hF);
        for (int l = 0; l < 8; l++) do_read(AW'(l), TW'(l + 3), "R5 full-line data");

        // R5 sweep of every byte-enable pattern on line 0
        for (int be = 0; be < 16; be++) begin
            do_write(3'd0, 32'hF0E1_D2C3 ^ (32'(be) * 32'h1111_1111), LB'(be));
            do_read(3'd0, TW'(be), "R5 masked data");
        end

        // R10 capture at acceptance
        old = bm[2];
        i_v = 1'b1; i_w = 1'b0; i_a = 3'd2; i_t = 4'd9;
        cyc();
        do_write(3'd2, 32'hDEAD_BEEF, 4'hF);
        for (int k = 0; k < LAT - 1; k++) cyc();
        cyc();
        chk(s_rv == 1'b1, "R10 reply present", s_rv, 1);
        chk(s_data == old, "R10 old data", s_data, old);
        do_read(3'd2, 4'd10, "R10 new data");

        // R8 full table and R3 ordered drain under consumer stall
        i_rr = 1'b0;
        for (int j = 0; j < 5; j++) begin
            i_v = 1'b1; i_w = 1'b0; i_a = AW'(j); i_t = TW'(j + 1);
            cyc();
            chk(s_rdy == (j < 4), "R8 full refusal", s_rdy, (j < 4));
        end
        i_v = 1'b0;
        for (int k = 0; k < 5; k++) begin
            cyc();
            chk(s_rv == 1'b0, "R4 held by rsp_ready", s_rv, 0);
        end
        i_rr = 1'b1;
        for (int j = 0; j < 4; j++) begin
            cyc();
            chk(s_rv == 1'b1, "R3 drain valid", s_rv, 1);
            chk(s_tag == TW'(j + 1), "R3 drain order", s_tag, j + 1);
            chk(s_data == bm[j], "R3 drain data", s_data, bm[j]);
        end
        cyc();
        chk(s_rv == 1'b0, "R4 empty after drain", s_rv, 0);

        // R6 periodic stall with an empty table
        i_sm = 1'b1;
        for (int k = 0; k < 15; k++) begin
            cyc();
            chk(s_rdy == ((s_idx % PER) != 0), "R6 periodic stall", s_rdy, ((s_idx % PER) != 0));
        end

        // R7 occupancy stall with the consumer held off
        i_rr = 1'b0; occ = 0;
        for (int k = 0; k < 9; k++) begin
            i_v = 1'b1; i_w = 1'b0; i_a = AW'(k + 4); i_t = TW'(k + 6);
            cyc();
            chk(s_rdy == !(((s_idx % PER) == 0) || (occ >= LIM)), "R7 occupancy stall",
                s_rdy, !(((s_idx % PER) == 0) || (occ >= LIM)));
            if (s_rdy && occ < 4) begin
                q_tag[occ] = TW'(k + 6); q_dat[occ] = bm[AW'(k + 4)]; occ++;
            end
        end

        // R9 write refused while the table is crowded
        i_v = 1'b1; i_w = 1'b1; i_a = 3'd7; i_d = ~bm[7]; i_be = 4'hF;
        cyc();
        i_v = 1'b0;
        chk(s_rdy == 1'b0, "R9 refused write", s_rdy, 0);

        i_rr = 1'b1;
        for (int j = 0; j < 3; j++) begin
            cyc();
            chk(s_rv == 1'b1, "R3 stall drain valid", s_rv, 1);
            chk(s_tag == q_tag[j], "R3 stall drain order", s_tag, q_tag[j]);
            chk(s_data == q_dat[j], "R3 stall drain data", s_data, q_dat[j]);
        end
        cyc();
        chk(s_rv == 1'b0, "R9 no extra entry", s_rv, 0);

        i_sm = 1'b0;
        do_read(3'd7, 4'd15, "R9 line unchanged");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule